// File: doc/BRIEF.md
# Indirect Configuration Register Bank with Keyed Soft Reset

This block holds the configuration that an I2C bus controller's timing logic needs, and the host reaches it through only two byte-wide ports. Port 0 is an index. Port 1 is a window onto the internal register that the index currently selects. Five internal registers drive dedicated outputs:

- the controller's own bus address;
- a timeout value;
- a two-bit bus speed mode;
- the SCL low-phase length, in oscillator periods;
- the SCL high-phase length, in oscillator periods.

One index holds no storage. It is a guarded reset slot. The host writes 0xA5 and then 0x5A through the data window while the index points at that slot. That raises a one-clock soft reset pulse for the controller and returns the whole bank, pointer included, to its defaults. Any other byte breaks the sequence, and so does any other host write. The host must then start again with 0xA5.

The external reset is asynchronous and active low. Its release is synchronised to the clock inside the block, so registers leave reset two clocks after `rst_n` rises.

Top module: `irb_bank`

## Requirements
- R1: A host write with `host_sel`=0 loads the low 3 bits of `host_wdata` into the pointer. While `host_sel`=0, `host_rdata` shows the pointer zero-extended to 8 bits.
- R2: A host write with `host_sel`=1 updates the register at the current pointer. The mapping is index 0 own address, 1 timeout, 2 mode, 3 SCL low count and 4 SCL high count. While `host_sel`=1, `host_rdata` returns that register. A value in index 0 reads back unchanged after the other registers are written.
- R3: The mode register keeps only bits [1:0] of the written byte, and reads back as {6'b0, mode}. `bus_mode_o` encodes 00 standard, 01 fast, 10 fast-plus and 11 turbo.
- R4: The SCL low and high counts hold any 8-bit value from 0 to 255, and appear unchanged on `scl_low_o` and `scl_high_o`.
- R5: After hardware reset the defaults apply:
  - pointer 0;
  - own address 0xE0;
  - timeout 0xFF;
  - mode 0x00;
  - SCL low 0x9D;
  - SCL high 0x86;
  - `soft_rst_o` low.
- R6: The reset slot is index 5. Writing 0xA5 and then 0x5A there, with no other host write between them, drives `soft_rst_o` high for exactly one clock. The pulse starts at the clock edge that captures the 0x5A write.
- R7: At the edge where the pulse starts, every configuration register returns to its R5 default and the pointer returns to 0.
- R8: After 0xA5, any byte written to the reset slot other than 0x5A abandons the key, and so does any other host write. This includes a second 0xA5, so A5, A5, 5A gives no pulse.
- R9: Reading index 5, 6 or 7 returns 0x00. Writes to index 6 or 7 change no register.
- R10: A 0x5A written to the reset slot without a preceding 0xA5 produces no pulse and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr | input | 1 | Host write strobe, one byte per cycle |
| host_sel | input | 1 | 0 selects the pointer port, 1 the data window |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read value of the port chosen by host_sel |
| own_addr_o | output | 8 | Own bus address register |
| timeout_o | output | 8 | Timeout register |
| bus_mode_o | output | 2 | Bus speed mode |
| scl_low_o | output | 8 | SCL low-phase count |
| scl_high_o | output | 8 | SCL high-phase count |
| soft_rst_o | output | 1 | One-clock soft reset pulse |

## Verification
The bench aims at the key sequence's weak points:
- **A repeated 0xA5.** A design that stays armed after a second 0xA5 would pulse on A5, A5, 5A.
- **A pointer write between the two key bytes.** A design that only watches data bytes would accept a key split by a pointer write.
- **A lone 0x5A.** A design that arms on any write would fire here.

It checks that the pulse lands in the cycle after the 0x5A write and drops one cycle later. It also checks that the pointer returns to 0 along with the registers, so that a bank which left the pointer alone would show up on the next read.

Random traffic mixes pointer moves, writes to unused slots and stray key bytes. That would expose a write leaking into a neighbouring register, a mode register keeping more than two bits, or a nonzero read from the reset or unused slots.

// File: rtl/irb_pkg.sv
package irb_pkg;
  localparam int DW       = 8;
  localparam int PTR_W    = 3;
  localparam int NREG     = 5;
  localparam int IDX_OWN  = 0;
  localparam int IDX_TMO  = 1;
  localparam int IDX_MODE = 2;
  localparam int IDX_SCLL = 3;
  localparam int IDX_SCLH = 4;
  localparam int IDX_RST  = 5;
  localparam int MODE_W   = 2;
  localparam logic [DW-1:0] KEY_FIRST  = 8'hA5;
  localparam logic [DW-1:0] KEY_SECOND = 8'h5A;

  typedef enum logic [MODE_W-1:0] {
    MODE_STD   = 2'b00,
    MODE_FAST  = 2'b01,
    MODE_FASTP = 2'b10,
    MODE_TURBO = 2'b11
  } bus_mode_e;
endpackage

// File: rtl/irb_rst_sync.sv
module irb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/irb_keyseq.sv
module irb_keyseq
  import irb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_wr,
  input  logic          other_wr,
  input  logic [DW-1:0] wdata,
  output logic          fire,
  output logic          pulse_q
);
  logic armed_q, armed_d, armed_en;

  always_comb begin
    fire     = key_wr && armed_q && (wdata == KEY_SECOND);
    armed_en = key_wr || other_wr;
    armed_d  = armed_q;
    if (key_wr)        armed_d = !armed_q && (wdata == KEY_FIRST);
    else if (other_wr) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (armed_en) armed_q <= armed_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= fire;
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q); // R6
  AST_KEY_ABANDON: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && key_wr && wdata != KEY_SECOND) |=> !pulse_q); // R8
  AST_OTHER_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (other_wr && !key_wr) |=> !armed_q); // R8
endmodule

// File: rtl/irb_regfile.sv
module irb_regfile
  import irb_pkg::*;
#(
  parameter logic [NREG*DW-1:0] DEFAULTS = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             wr,
  input  logic             sel,
  input  logic [DW-1:0]    wdata,
  output logic [PTR_W-1:0] ptr_q,
  output logic [DW-1:0]    rdata,
  output logic [NREG*DW-1:0] cfg_flat
);
  logic [PTR_W-1:0] ptr_d;
  logic             ptr_en;
  logic [DW-1:0]    cfg_q [NREG];
  logic [DW-1:0]    cfg_d [NREG];
  logic [NREG-1:0]  cfg_en;

  always_comb begin
    ptr_en = soft_clr || (wr && !sel);
    ptr_d  = soft_clr ? '0 : wdata[PTR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      cfg_en[i] = soft_clr || (wr && sel && ptr_q == PTR_W'(i));
      if (soft_clr)          cfg_d[i] = DEFAULTS[i*DW +: DW];
      else if (i == IDX_MODE) cfg_d[i] = {{(DW-MODE_W){1'b0}}, wdata[MODE_W-1:0]};
      else                   cfg_d[i] = wdata;
    end
  end

  for (genvar gi = 0; gi < NREG; gi++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cfg_q[gi] <= DEFAULTS[gi*DW +: DW];
      else if (cfg_en[gi]) cfg_q[gi] <= cfg_d[gi];
    end
    assign cfg_flat[gi*DW +: DW] = cfg_q[gi];
  end

  always_comb begin
    rdata = '0;
    if (!sel)                   rdata = {{(DW-PTR_W){1'b0}}, ptr_q};
    else if (int'(ptr_q) < NREG) rdata = cfg_q[ptr_q];
  end

  AST_UNUSED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel && int'(ptr_q) >= NREG && !soft_clr) |=> $stable(cfg_flat)); // R9
  AST_PTR_HOLDS_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel && !soft_clr) |=> $stable(ptr_q)); // R1
endmodule

// File: rtl/irb_bank.sv
module irb_bank
  import irb_pkg::*;
#(
  parameter logic [7:0] OWN_DEF  = 8'hE0,
  parameter logic [7:0] TMO_DEF  = 8'hFF,
  parameter logic [7:0] MODE_DEF = 8'h00,
  parameter logic [7:0] SCLL_DEF = 8'h9D,
  parameter logic [7:0] SCLH_DEF = 8'h86
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic       host_sel,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic [7:0] own_addr_o,
  output logic [7:0] timeout_o,
  output logic [1:0] bus_mode_o,
  output logic [7:0] scl_low_o,
  output logic [7:0] scl_high_o,
  output logic       soft_rst_o
);
  localparam logic [NREG*DW-1:0] DEFAULTS = {SCLH_DEF, SCLL_DEF, MODE_DEF, TMO_DEF, OWN_DEF};

  logic               rst_sync_n;
  logic [PTR_W-1:0]   ptr;
  logic [NREG*DW-1:0] cfg_flat;
  logic               key_wr, other_wr, fire;

  irb_rst_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign key_wr   = host_wr && host_sel && (ptr == PTR_W'(IDX_RST));
  assign other_wr = host_wr && !key_wr;

  irb_keyseq u_key (
    .clk(clk), .rst_n(rst_sync_n), .key_wr(key_wr), .other_wr(other_wr),
    .wdata(host_wdata), .fire(fire), .pulse_q(soft_rst_o)
  );

  irb_regfile #(.DEFAULTS(DEFAULTS)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .soft_clr(fire), .wr(host_wr),
    .sel(host_sel), .wdata(host_wdata), .ptr_q(ptr), .rdata(host_rdata),
    .cfg_flat(cfg_flat)
  );

  assign own_addr_o = cfg_flat[IDX_OWN*DW  +: DW];
  assign timeout_o  = cfg_flat[IDX_TMO*DW  +: DW];
  assign bus_mode_o = cfg_flat[IDX_MODE*DW +: MODE_W];
  assign scl_low_o  = cfg_flat[IDX_SCLL*DW +: DW];
  assign scl_high_o = cfg_flat[IDX_SCLH*DW +: DW];

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(soft_rst_o) |-> $past(host_wr && host_sel && ptr == PTR_W'(IDX_RST)
                                && host_wdata == KEY_SECOND)); // R6
  AST_PULSE_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    soft_rst_o |-> (own_addr_o == OWN_DEF && timeout_o == TMO_DEF
                    && scl_low_o == SCLL_DEF && scl_high_o == SCLH_DEF
                    && bus_mode_o == MODE_DEF[MODE_W-1:0])); // R7
  AST_PTR_CLEARED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (soft_rst_o && !$past(host_wr && !host_sel)) |-> host_sel || host_rdata == 8'h00); // R7
endmodule

// File: tb/tb_irb_bank.sv
module tb_irb_bank;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n, host_wr, host_sel;
  logic [7:0] host_wdata, host_rdata, own_addr_o, timeout_o, scl_low_o, scl_high_o;
  logic [1:0] bus_mode_o;
  logic       soft_rst_o;

  irb_bank dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .own_addr_o(own_addr_o),
    .timeout_o(timeout_o), .bus_mode_o(bus_mode_o), .scl_low_o(scl_low_o),
    .scl_high_o(scl_high_o), .soft_rst_o(soft_rst_o)
  );

  int checks = 0, errors = 0;
  logic [7:0] m_reg [5];
  int   m_ptr;
  bit   m_armed;
  bit   done = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] def_of(int i);
    case (i)
      0: return 8'hE0;
      1: return 8'hFF;
      2: return 8'h00;
      3: return 8'h9D;
      default: return 8'h86;
    endcase
  endfunction

  function automatic logic [7:0] exp_data(int p);
    if (p < 5) return m_reg[p];
    return 8'h00;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic model_defaults();
    for (int i = 0; i < 5; i++) m_reg[i] = def_of(i);
    m_ptr = 0;
    m_armed = 0;
  endtask

  task automatic check_all(string req);
    chk(req, own_addr_o, m_reg[0]);
    chk(req, timeout_o, m_reg[1]);
    chk(req, {6'b0, bus_mode_o}, m_reg[2]);
    chk(req, scl_low_o, m_reg[3]);
    chk(req, scl_high_o, m_reg[4]);
    host_sel = 1'b0; #1;
    chk(req, host_rdata, 8'(m_ptr));
    host_sel = 1'b1; #1;
    chk(req, host_rdata, exp_data(m_ptr));
  endtask

  task automatic do_write(bit sel, logic [7:0] d, string req);
    bit fire_e = 0;
    if (!sel) begin
      m_ptr = int'(d[2:0]);
      m_armed = 0;
    end else if (m_ptr == 5) begin
      fire_e  = m_armed && d == 8'h5A;
      m_armed = !m_armed && d == 8'hA5;
    end else begin
      m_armed = 0;
      if (m_ptr == 2) m_reg[2] = {6'b0, d[1:0]};
      else if (m_ptr < 5) m_reg[m_ptr] = d;
    end
    host_wr = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
    chk({req, " R6 pulse"}, {7'b0, soft_rst_o}, {7'b0, fire_e});
    if (fire_e) begin
      model_defaults();
      check_all("R7 defaults on soft reset");
      @(negedge clk);
      chk("R6 pulse one cycle", {7'b0, soft_rst_o}, 8'h00);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int unused_seed;
    unused_seed = $urandom(32'h1234);
    rst_n = 1'b0; host_wr = 1'b0; host_sel = 1'b0; host_wdata = 8'h00;
    model_defaults();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 pulse low", {7'b0, soft_rst_o}, 8'h00);
    check_all("R5 reset defaults");

    // R1 R2 own address survives writes to others
    do_write(0, 8'h00, "R1"); do_write(1, 8'h42, "R2");
    for (int i = 1; i < 5; i++) begin
      do_write(0, 8'(i), "R1");
      do_write(1, 8'hC3 ^ 8'(i), "R2");
    end
    do_write(0, 8'h00, "R1");
    check_all("R2 own address readback");
    // R1 pointer keeps only 3 bits
    do_write(0, 8'hFB, "R1");
    check_all("R1 pointer masked");
    // R3 modes
    for (int m = 0; m < 4; m++) begin
      do_write(0, 8'h02, "R3"); do_write(1, 8'hFC | 8'(m), "R3");
      chk("R3 mode output", {6'b0, bus_mode_o}, 8'(m));
      check_all("R3 mode readback");
    end
    // R4 SCL extremes
    do_write(0, 8'h03, "R4"); do_write(1, 8'hFF, "R4");
    do_write(0, 8'h04, "R4"); do_write(1, 8'h00, "R4");
    check_all("R4 scl extremes");
    // R9 unused and reset slot reads/writes
    do_write(0, 8'h06, "R9"); do_write(1, 8'h77, "R9");
    check_all("R9 unused index 6");
    do_write(0, 8'h07, "R9"); do_write(1, 8'h11, "R9");
    check_all("R9 unused index 7");
    do_write(0, 8'h05, "R9");
    check_all("R9 reset slot reads zero");
    // R10 lone second key byte
    do_write(1, 8'h5A, "R10 lone 5A");
    check_all("R10 no change");
    // R8 repeated A5
    do_write(1, 8'hA5, "R8"); do_write(1, 8'hA5, "R8"); do_write(1, 8'h5A, "R8 A5 A5 5A");
    check_all("R8 no reset after double A5");
    // R8 pointer write between key bytes
    do_write(1, 8'hA5, "R8"); do_write(0, 8'h05, "R8"); do_write(1, 8'h5A, "R8 split key");
    // R8 wrong byte then 5A
    do_write(1, 8'hA5, "R8"); do_write(1, 8'h33, "R8"); do_write(1, 8'h5A, "R8 wrong byte");
    // R6 R7 valid key
    do_write(1, 8'hA5, "R6"); do_write(1, 8'h5A, "R6 valid key");
    check_all("R7 after soft reset");

    // random traffic
    for (int n = 0; n < 600; n++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r < 3) do_write(0, 8'($urandom_range(0, 255)), "R1 rand");
      else begin
        d = 8'($urandom_range(0, 255));
        if (r == 7) d = 8'hA5;
        if (r >= 8) d = 8'h5A;
        if (r == 6 && m_ptr != 5) begin
          do_write(0, 8'h05, "R6 rand");
          d = 8'hA5;
        end
        do_write(1, d, "R2 rand");
      end
      if (n % 8 == 0) check_all("R2 R9 random state");
    end
    check_all("R2 final state");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule